// File: doc/BRIEF.md
# Multi-Lane Serial Synthesizer Program Bus

This block is a serial program master that sends five 24-bit program words at the same time, one word per serial data lane. All five lanes share one data clock and one latch strobe. The master shifts the words out most significant bit first. Data changes on the falling clock edge, so a receiver samples it on the rising edge. After the 24th bit, the master raises the latch strobe for one serial clock period, with the data clock held low, and then returns to idle.

Lanes 0 to 3 each drive a frequency-synthesizer loop device. Such a device discards the leading 5 bits of the stream and keeps the final 19. Lane 4 carries system control. Its leading 8 bits go to one target and its trailing 16 bits go to another.

The top also contains a receiver model that recovers these fields from the serial lines. The model changes its outputs only when the latch strobe arrives. The pair can therefore be used as one block: parallel words go in at the master, and the fields each target would hold come out of the model.

Top module: `synthProgBus`

## Requirements
- R1: During and after reset, `busy`, `serClk`, `latchOut` and every bit of `laneData` are 0, and `pllField`, `ctrlFirst` and `ctrlLast` are 0 until the first transfer completes.
- R2: When `start` is high while idle, the master takes lane i's word from `wordsIn[i*24 +: 24]`. `busy` is high from the next cycle until the latch pulse ends.
- R3: Each transfer makes exactly 24 rising edges on `serClk`. Each clock half lasts HALF_DIV = 2 system cycles. `serClk` is low whenever `busy` is low.
- R4: Bits go out most significant first. A lane's data changes only together with a falling edge of `serClk`, and stays stable while `serClk` is high. All lanes are 0 while idle.
- R5: After the 24th bit, `latchOut` is high for one serial period (2*HALF_DIV = 4 system cycles) with `serClk` low throughout. `busy` and `latchOut` fall in the same cycle.
- R6: For loop lane i (i = 0 to 3), `pllField[i*19 +: 19]` becomes bits 18:0 of that lane's word, meaning its last 19 bits. The first 5 bits have no effect.
- R7: For the control lane (lane 4), `ctrlFirst` becomes word bits 23:16 (the first 8 bits sent), and `ctrlLast` becomes word bits 15:0 (the last 16 bits sent).
- R8: The receiver outputs change only in the cycle after `latchOut` rises, never while bits are shifting.
- R9: A `start` pulse while `busy` is high is ignored. It does not change the transfer in progress and does not queue another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| wordsIn | input | 120 | Five 24-bit words, lane i at bits i*24 +: 24 |
| busy | output | 1 | Transfer in progress |
| serClk | output | 1 | Shared serial data clock |
| latchOut | output | 1 | Shared latch strobe |
| laneData | output | 5 | Serial data, one bit per lane |
| pllField | output | 76 | Receiver model: kept 19 bits per loop lane, lane i at i*19 +: 19 |
| ctrlFirst | output | 8 | Receiver model: first control field |
| ctrlLast | output | 16 | Receiver model: second control field |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a transfer. The words it carries differ from the ones being sent, and it must leave no trace in either the serial stream or the latched fields. The stimulus pulses `start` with unrelated words partway through a shift. The bench then checks that the recovered fields match the first words, and that the bus stays quiet afterwards. The word patterns use leading 5 bits that differ from the trailing ones, so the bench can tell the discarded prefix from the 8/16 split on the control lane.

// File: rtl/progbus_pkg.sv
package progbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } seqState_t;

  // strobes from sequencer to lane datapath
  typedef struct packed {
    logic load;   // capture parallel words
    logic shift;  // advance every lane by one bit
    logic clear;  // zero the lanes at end of transfer
  } laneCmd_t;

endpackage

// File: rtl/progSeq.sv
module progSeq
  import progbus_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output laneCmd_t cmd,
  output logic     busy,
  output logic     serClk,
  output logic     latchOut
);

  localparam int PH_W  = $clog2(2 * HALF_DIV) + 1;
  localparam int BIT_W = $clog2(WORD_W) + 1;
  localparam logic [PH_W-1:0]  HALF_END  = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0]  LATCH_END = PH_W'(2 * HALF_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  seqState_t        state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;
  logic             clkReg;
  logic             latchReg;

  logic halfDone;
  logic latchDone;
  logic lastBit;

  always_comb begin
    halfDone  = (phase == HALF_END);
    latchDone = (phase == LATCH_END);
    lastBit   = (bitCnt == LAST_BIT);
    cmd.load  = (state == ST_IDLE) && start;
    cmd.shift = (state == ST_SHIFT) && halfDone && clkReg && !lastBit;
    cmd.clear = (state == ST_LATCH) && latchDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitCnt   <= '0;
      clkReg   <= 1'b0;
      latchReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SHIFT;
            phase  <= '0;
            bitCnt <= '0;
            clkReg <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (halfDone) begin
            phase  <= '0;
            clkReg <= ~clkReg;
            if (clkReg) begin
              if (lastBit) begin
                state    <= ST_LATCH;
                latchReg <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_LATCH: begin
          if (latchDone) begin
            phase    <= '0;
            latchReg <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign serClk   = clkReg;
  assign latchOut = latchReg;

endmodule

// File: rtl/progLanes.sv
module progLanes
  import progbus_pkg::*;
#(
  parameter int LANES  = 5,
  parameter int WORD_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneCmd_t                cmd,
  input  logic [LANES*WORD_W-1:0] wordsIn,
  output logic [LANES-1:0]        laneData
);

  for (genvar gi = 0; gi < LANES; gi++) begin : gLane
    logic [WORD_W-1:0] shReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg <= '0;
      end else if (cmd.load) begin
        shReg <= wordsIn[gi*WORD_W +: WORD_W];
      end else if (cmd.clear) begin
        shReg <= '0;
      end else if (cmd.shift) begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
    end

    assign laneData[gi] = shReg[WORD_W-1];
  end

endmodule

// File: rtl/progRecvModel.sv
module progRecvModel #(
  parameter int LANES   = 5,
  parameter int WORD_W  = 24,
  parameter int SKIP_W  = 5,
  parameter int FIRST_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  serClk,
  input  logic                                  latchIn,
  input  logic [LANES-1:0]                      laneData,
  output logic [(LANES-1)*(WORD_W-SKIP_W)-1:0]  pllField,
  output logic [FIRST_W-1:0]                    ctrlFirst,
  output logic [WORD_W-FIRST_W-1:0]             ctrlLast
);

  localparam int KEEP_W = WORD_W - SKIP_W;
  localparam int LAST_W = WORD_W - FIRST_W;
  localparam int CTL    = LANES - 1;

  logic clkQ;
  logic latchQ;
  logic sampleEn;
  logic updateEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ   <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      clkQ   <= serClk;
      latchQ <= latchIn;
    end
  end

  assign sampleEn = serClk && !clkQ;
  assign updateEn = latchIn && !latchQ;

  logic [WORD_W-1:0] capReg [LANES];

  for (genvar gi = 0; gi < LANES; gi++) begin : gCap
    always_ff @(posedge clk) begin
      if (!rstN)
        capReg[gi] <= '0;
      else if (sampleEn)
        capReg[gi] <= {capReg[gi][WORD_W-2:0], laneData[gi]};
    end
  end

  for (genvar gp = 0; gp < CTL; gp++) begin : gPll
    always_ff @(posedge clk) begin
      if (!rstN)
        pllField[gp*KEEP_W +: KEEP_W] <= '0;
      else if (updateEn)
        pllField[gp*KEEP_W +: KEEP_W] <= capReg[gp][KEEP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlFirst <= '0;
      ctrlLast  <= '0;
    end else if (updateEn) begin
      ctrlFirst <= capReg[CTL][WORD_W-1 -: FIRST_W];
      ctrlLast  <= capReg[CTL][LAST_W-1:0];
    end
  end

endmodule

// File: rtl/synthProgBus.sv
module synthProgBus
  import progbus_pkg::*;
#(
  parameter int LANES    = 5,
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2,
  parameter int SKIP_W   = 5,
  parameter int FIRST_W  = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 start,
  input  logic [LANES*WORD_W-1:0]              wordsIn,
  output logic                                 busy,
  output logic                                 serClk,
  output logic                                 latchOut,
  output logic [LANES-1:0]                     laneData,
  output logic [(LANES-1)*(WORD_W-SKIP_W)-1:0] pllField,
  output logic [FIRST_W-1:0]                   ctrlFirst,
  output logic [WORD_W-FIRST_W-1:0]            ctrlLast
);

  laneCmd_t cmd;

  progSeq #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd),
    .busy(busy), .serClk(serClk), .latchOut(latchOut)
  );

  progLanes #(.LANES(LANES), .WORD_W(WORD_W)) uLanes (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wordsIn(wordsIn), .laneData(laneData)
  );

  progRecvModel #(.LANES(LANES), .WORD_W(WORD_W), .SKIP_W(SKIP_W), .FIRST_W(FIRST_W)) uRecv (
    .clk(clk), .rstN(rstN), .serClk(serClk), .latchIn(latchOut), .laneData(laneData),
    .pllField(pllField), .ctrlFirst(ctrlFirst), .ctrlLast(ctrlLast)
  );

endmodule

// File: rtl/synthProgBusChk.sv
module synthProgBusChk #(
  parameter int LANES  = 5,
  parameter int PLL_W  = 76,
  parameter int FIRST_W = 8,
  parameter int LAST_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               serClk,
  input logic               latchOut,
  input logic [LANES-1:0]   laneData,
  input logic [PLL_W-1:0]   pllField,
  input logic [FIRST_W-1:0] ctrlFirst,
  input logic [LAST_W-1:0]  ctrlLast
);

  // R3: serial clock parked low when idle
  a_r3_clk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serClk);

  // R4: lanes hold while the serial clock is high
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(laneData));

  // R4: lanes are zero when idle
  a_r4_lanes_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (laneData == '0));

  // R5: no clock activity during the latch pulse
  a_r5_latch_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    latchOut |-> !serClk);

  // R5: busy ends together with the latch pulse
  a_r5_busy_ends_latch: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(latchOut) && !latchOut));

  // R8: fields move only right after the latch rises
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(latchOut && !$past(latchOut)) |=>
      ($stable(pllField) && $stable(ctrlFirst) && $stable(ctrlLast)));

endmodule

bind synthProgBus synthProgBusChk #(
  .LANES(LANES), .PLL_W((LANES-1)*(WORD_W-SKIP_W)),
  .FIRST_W(FIRST_W), .LAST_W(WORD_W-FIRST_W)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .serClk(serClk), .latchOut(latchOut),
  .laneData(laneData), .pllField(pllField), .ctrlFirst(ctrlFirst), .ctrlLast(ctrlLast)
);

// File: tb/sim_synthProgBus.sv
module sim_synthProgBus;

  localparam int LN = 5;
  localparam int WW = 24;
  localparam int TOT = LN * WW;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [TOT-1:0] wordsIn = '0;
  logic           busy, serClk, latchOut;
  logic [LN-1:0]  laneData;
  logic [75:0]    pllField;
  logic [7:0]     ctrlFirst;
  logic [15:0]    ctrlLast;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [TOT-1:0] expQ [$];

  always #4 clk = ~clk;

  synthProgBus u0 (
    .clk(clk), .rstN(rstN), .start(start), .wordsIn(wordsIn), .busy(busy),
    .serClk(serClk), .latchOut(latchOut), .laneData(laneData),
    .pllField(pllField), .ctrlFirst(ctrlFirst), .ctrlLast(ctrlLast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // driver: issue a transfer and push its expectation (R2)
  task automatic sendWords(input logic [TOT-1:0] w);
    @(negedge clk);
    while (busy) @(negedge clk);
    wordsIn = w;
    start   = 1'b1;
    expQ.push_back(w);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", 128'(busy), 128'(1));
  endtask

  // monitor: sniff serial lines and compare at end of each transfer
  logic           prevClk = 0, prevBusy = 0, prevLatch = 0;
  logic [LN-1:0]  prevLane = '0;
  int             edgeCnt = 0, highLen = 0, latchLen = 0;
  logic [WW-1:0]  cap [LN];
  logic [75:0]    heldPll;
  logic [7:0]     heldFirst;
  logic [15:0]    heldLast;

  initial begin
    for (int i = 0; i < LN; i++) cap[i] = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (busy && !prevBusy) begin
          heldPll = pllField; heldFirst = ctrlFirst; heldLast = ctrlLast;
        end
        if (serClk && !prevClk) begin
          edgeCnt++;
          for (int i = 0; i < LN; i++) cap[i] = {cap[i][WW-2:0], laneData[i]};
        end
        if (serClk) highLen++;
        if (!serClk && prevClk) begin
          chk(highLen == 2, "R3", "clock high half length", 128'(highLen), 128'(2));
          highLen = 0;
        end
        if (serClk && prevClk)
          chk(laneData == prevLane, "R4", "lane stable while clock high",
              128'(laneData), 128'(prevLane));
        if (latchOut) begin
          latchLen++;
          chk(!serClk, "R5", "clock low during latch", 128'(serClk), 128'(0));
        end
        if (busy && !latchOut && !prevLatch)
          chk({pllField, ctrlFirst, ctrlLast} == {heldPll, heldFirst, heldLast},
              "R8", "fields held while shifting",
              128'({pllField, ctrlFirst, ctrlLast}), 128'({heldPll, heldFirst, heldLast}));
        if (prevBusy && !busy) begin
          logic [TOT-1:0] w;
          chk(expQ.size() != 0, "R9", "unexpected transfer", 128'(expQ.size()), 128'(1));
          if (expQ.size() != 0) begin
            w = expQ.pop_front();
            chk(edgeCnt == WW, "R3", "rising edges per transfer", 128'(edgeCnt), 128'(WW));
            chk(latchLen == 4, "R5", "latch pulse length", 128'(latchLen), 128'(4));
            chk(prevLatch && !latchOut, "R5", "latch falls with busy",
                128'({prevLatch, latchOut}), 128'(2'b10));
            for (int i = 0; i < LN; i++)
              chk(cap[i] == w[i*WW +: WW], "R4", "MSB-first lane word",
                  128'(cap[i]), 128'(w[i*WW +: WW]));
            for (int i = 0; i < LN - 1; i++)
              chk(pllField[i*19 +: 19] == w[i*WW +: 19], "R6", "loop lane kept bits",
                  128'(pllField[i*19 +: 19]), 128'(w[i*WW +: 19]));
            chk(ctrlFirst == w[4*WW+16 +: 8], "R7", "control first field",
                128'(ctrlFirst), 128'(w[4*WW+16 +: 8]));
            chk(ctrlLast == w[4*WW +: 16], "R7", "control last field",
                128'(ctrlLast), 128'(w[4*WW +: 16]));
          end
          edgeCnt = 0; latchLen = 0;
        end
      end
      prevClk = serClk; prevBusy = busy; prevLatch = latchOut; prevLane = laneData;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "run timed out", 128'(0), 128'(1));
    finishRun();
  end

  function automatic logic [TOT-1:0] mkWords(input logic [WW-1:0] seed);
    logic [TOT-1:0] w;
    for (int i = 0; i < LN; i++)
      w[i*WW +: WW] = seed ^ (WW'(i) * 24'h13579B) ^ {WW{i[0]}};
    return w;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !serClk && !latchOut, "R1", "control outputs in reset",
        128'({busy, serClk, latchOut}), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk(laneData == '0, "R1", "lanes after reset", 128'(laneData), 128'(0));
    chk({pllField, ctrlFirst, ctrlLast} == '0, "R1", "fields after reset",
        128'({pllField, ctrlFirst, ctrlLast}), 128'(0));
    chk(!busy && !serClk, "R3", "idle clock low", 128'({busy, serClk}), 128'(0));

    // varied patterns; leading 5 bits differ from trailing ones (R6)
    sendWords({LN{24'hF80000}});
    sendWords({LN{24'h07FFFF}});
    sendWords(mkWords(24'hA5C33C));
    sendWords({LN{24'hAAAAAA}});
    sendWords(mkWords(24'h123456));   // back-to-back issue
    sendWords('0);

    // R9: start during a transfer is ignored
    sendWords(mkWords(24'h5EED01));
    repeat (30) @(negedge clk);
    wordsIn = mkWords(24'hBAD0BA);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy && !serClk && !latchOut, "R9", "no queued transfer after ignored start",
        128'({busy, serClk, latchOut}), 128'(0));
    chk(expQ.size() == 0, "R9", "scoreboard drained", 128'(expQ.size()), 128'(0));
    chk(laneData == '0, "R4", "lanes zero when idle", 128'(laneData), 128'(0));

    finishRun();
  end

endmodule